// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. The distributor presents a single candidate interrupt: an ID, an 8-bit priority value where lower means more urgent, and, for software-generated IDs, the number of the CPU that raised it. The block decides whether that candidate may interrupt the processor and drives the request line when it may. The decision uses an enable bit, a software priority mask and the priority of the interrupt currently being serviced.

Software uses a 32-bit register bus with word select. A read of the acknowledge register claims the candidate. The read returns its ID, records it as active on a small stack and sends a one-cycle acknowledge pulse so that the distributor clears the pending state. When nothing qualifies, the read returns the spurious ID 1023 and leaves all state as it was. A write of the end-of-interrupt register with the matching value pops the active entry and sends a one-cycle retire pulse to the distributor. A more urgent candidate may preempt the one being serviced, up to the stack depth.

Top module: `cpu_irq_iface`

## Requirements
- R1: Control register (select 0) bit 0 enables signalling; while it is 0, `irq_o` stays low whatever the candidate.
- R2: `irq_o` rises only for a candidate whose priority is strictly below the mask register (select 1, bits 7:0). With a mask of 0xF0, priority 0xA0 is signalled and 0xF0 is not.
- R3: A read of select 2 while `irq_o` is high does three things on the next cycle. It returns the ID in bits 9:0, the source CPU in bits 12:10 when the ID is below 16 (zero otherwise) and zero in bits 31:13. It pulses `ack_o` with `ack_id_o` equal to the ID. It makes `irq_o` fall if the same candidate is still presented.
- R4: A read of select 2 while `irq_o` is low returns 1023, gives no `ack_o` pulse and changes no state.
- R5: A candidate ID above 1020 never qualifies.
- R6: A write to select 3 equal to the top active entry's value (as returned by R3) retires it and pulses `eoi_o` with `eoi_id_o` on the next cycle.
- R7: A write to select 3 is ignored when the stack is empty, or when any of bits 31:0 differ from the top entry's value, including the source bits of a software-generated ID. No `eoi_o` pulse follows and the active state stays as it was.
- R8: While an interrupt is active, only a candidate with a priority strictly below that of the top active entry is signalled. While the stack holds `ACT_DEPTH` entries, no candidate is signalled.
- R9: Right after the retiring write's clock edge, a candidate that the distributor still presents (a level source pending again) raises `irq_o`, with no idle cycle.
- R10: Reading select 0 returns the enable in bit 0 and zero above it. Reading select 1 returns the mask in bits 7:0 and zero above it. Reading select 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cand_valid_i | input | 1 | Distributor presents a candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| cand_src_i | input | 3 | Requesting CPU for IDs below 16 |
| ack_o | output | 1 | One-cycle pulse: candidate claimed |
| ack_id_o | output | 10 | ID claimed with `ack_o` |
| eoi_o | output | 1 | One-cycle pulse: active interrupt retired |
| eoi_id_o | output | 10 | ID retired with `eoi_o` |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 write, 0 read |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with `ACT_DEPTH` set to 2. Two nested claims are then enough to fill the stack, so the full-stack block of R8 can be reached with a few register accesses. It then retires the inner entry while the same level candidate is still presented, which exercises the immediate reassertion of R9 against a non-empty stack. It also retires the outer entry afterwards, so both pop positions of the stack are covered.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int ID_W   = 10;
  localparam int SRC_W  = 3;
  localparam int PRIO_W = 8;
  localparam int VAL_W  = ID_W + SRC_W;

  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam logic [ID_W-1:0] MAX_ID      = 10'd1020;
  localparam logic [ID_W-1:0] SOFT_LIMIT  = 10'd16;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } act_entry_t;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_PMASK = 2'd1,
    SEL_ACK   = 2'd2,
    SEL_EOI   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cpu_irq_cfg.sv
module cpu_irq_cfg
  import cpu_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_pmask_i,
  input  logic              en_bit_i,
  input  logic [PRIO_W-1:0] pmask_bits_i,
  output logic              en_o,
  output logic [PRIO_W-1:0] pmask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      pmask_o <= '0;
    end else begin
      if (wr_ctrl_i)  en_o    <= en_bit_i;
      if (wr_pmask_i) pmask_o <= pmask_bits_i;
    end
  end
endmodule

// File: rtl/cpu_irq_stack.sv
module cpu_irq_stack
  import cpu_irq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  act_entry_t push_entry_i,
  input  logic       pop_i,
  output act_entry_t top_o,
  output logic       empty_o,
  output logic       full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  act_entry_t         slot_q [DEPTH];
  logic [CNT_W-1:0]   cnt_q;

  // slot 0 is the top; push shifts down, pop shifts up
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[k] <= '0;
      end else if (push_i) begin
        if (k == 0) slot_q[k] <= push_entry_i;
        else        slot_q[k] <= slot_q[(k == 0) ? 0 : k-1];
      end else if (pop_i) begin
        if (k == DEPTH-1) slot_q[k] <= '0;
        else              slot_q[k] <= slot_q[(k == DEPTH-1) ? k : k+1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (push_i) cnt_q <= cnt_q + 1'b1;
    else if (pop_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign top_o   = slot_q[0];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_push_pop_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/cpu_irq_qual.sv
module cpu_irq_qual
  import cpu_irq_pkg::*;
(
  input  logic              en_i,
  input  logic [PRIO_W-1:0] pmask_i,
  input  logic [PRIO_W:0]   run_prio_i,
  input  logic              full_i,
  input  logic              valid_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              qual_o
);
  always_comb begin
    qual_o = en_i && valid_i && !full_i
          && (id_i <= MAX_ID)
          && (prio_i < pmask_i)
          && ({1'b0, prio_i} < run_prio_i);
  end
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpu_irq_pkg::*;
#(
  parameter int ACT_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cand_valid_i,
  input  logic [9:0]  cand_id_i,
  input  logic [7:0]  cand_prio_i,
  input  logic [2:0]  cand_src_i,
  output logic        ack_o,
  output logic [9:0]  ack_id_o,
  output logic        eoi_o,
  output logic [9:0]  eoi_id_o,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  logic              cfg_en;
  logic [PRIO_W-1:0] cfg_pmask;
  act_entry_t        stk_top, push_entry;
  logic              stk_empty, stk_full;
  logic [PRIO_W:0]   run_prio;
  logic              qual;
  logic              rd_req, wr_req, rd_ack, wr_eoi, do_ack, do_eoi;
  logic [VAL_W-1:0]  cand_val, top_val;

  assign rd_req = reg_req_i && !reg_we_i;
  assign wr_req = reg_req_i &&  reg_we_i;
  assign rd_ack = rd_req && (reg_addr_i == SEL_ACK);
  assign wr_eoi = wr_req && (reg_addr_i == SEL_EOI);

  cpu_irq_cfg i_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ctrl_i    (wr_req && (reg_addr_i == SEL_CTRL)),
    .wr_pmask_i   (wr_req && (reg_addr_i == SEL_PMASK)),
    .en_bit_i     (reg_wdata_i[0]),
    .pmask_bits_i (reg_wdata_i[PRIO_W-1:0]),
    .en_o         (cfg_en),
    .pmask_o      (cfg_pmask)
  );

  assign run_prio = stk_empty ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, stk_top.prio};

  cpu_irq_qual i_qual (
    .en_i       (cfg_en),
    .pmask_i    (cfg_pmask),
    .run_prio_i (run_prio),
    .full_i     (stk_full),
    .valid_i    (cand_valid_i),
    .id_i       (cand_id_i),
    .prio_i     (cand_prio_i),
    .qual_o     (qual)
  );

  assign irq_o = qual;

  // source CPU only travels with software-generated IDs
  assign cand_val = {(cand_id_i < SOFT_LIMIT) ? cand_src_i : {SRC_W{1'b0}}, cand_id_i};
  assign top_val  = {stk_top.src, stk_top.id};

  assign do_ack = rd_ack && qual;
  assign do_eoi = wr_eoi && !stk_empty
               && (reg_wdata_i == {{(32-VAL_W){1'b0}}, top_val});

  always_comb begin
    push_entry      = '0;
    push_entry.src  = cand_val[VAL_W-1:ID_W];
    push_entry.id   = cand_id_i;
    push_entry.prio = cand_prio_i;
  end

  cpu_irq_stack #(.DEPTH(ACT_DEPTH)) i_stack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (do_ack),
    .push_entry_i (push_entry),
    .pop_i        (do_eoi),
    .top_o        (stk_top),
    .empty_o      (stk_empty),
    .full_o       (stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o <= '0;
      ack_o       <= 1'b0;
      ack_id_o    <= '0;
      eoi_o       <= 1'b0;
      eoi_id_o    <= '0;
    end else begin
      ack_o <= do_ack;
      eoi_o <= do_eoi;
      if (do_ack) ack_id_o <= cand_id_i;
      if (do_eoi) eoi_id_o <= stk_top.id;
      if (rd_req) begin
        unique case (reg_addr_i)
          SEL_CTRL:  reg_rdata_o <= {31'b0, cfg_en};
          SEL_PMASK: reg_rdata_o <= {{(32-PRIO_W){1'b0}}, cfg_pmask};
          SEL_ACK:   reg_rdata_o <= do_ack ? {{(32-VAL_W){1'b0}}, cand_val}
                                           : {{(32-ID_W){1'b0}}, SPURIOUS_ID};
          default:   reg_rdata_o <= '0;
        endcase
      end
    end
  end

  p_irq_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en |-> !irq_o);
  p_irq_below_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cand_prio_i < cfg_pmask));
  p_ack_follows_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(irq_o && rd_ack));
  p_spurious_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack && !irq_o) |=> (!ack_o && reg_rdata_o == 32'd1023));
  p_id_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cand_id_i <= MAX_ID));
  p_eoi_from_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> $past(wr_eoi));
  p_nest_urgency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stk_empty) |-> (cand_prio_i < stk_top.prio));
endmodule

// File: tb/test_cpu_irq_iface.sv
module test_cpu_irq_iface;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic [2:0]  cand_src = '0;
  logic        ack, eoi, irq;
  logic [9:0]  ack_id, eoi_id;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int          total = 0, bad = 0;
  logic [31:0] rd_val;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cpu_irq_iface #(.ACT_DEPTH(2)) i_cpu_irq_iface (
    .clk_i(clk), .rst_ni(rst_n),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_prio_i(cand_prio),
    .cand_src_i(cand_src),
    .ack_o(ack), .ack_id_o(ack_id), .eoi_o(eoi), .eoi_id_o(eoi_id),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // en, mask, prio, expected irq
  localparam logic [17:0] VEC [8] = '{
    {1'b1, 8'hF0, 8'hA0, 1'b1},
    {1'b1, 8'hF0, 8'hF0, 1'b0},
    {1'b1, 8'hF0, 8'hEF, 1'b1},
    {1'b0, 8'hF0, 8'hA0, 1'b0},
    {1'b1, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'hFF, 8'hFE, 1'b1},
    {1'b1, 8'h01, 8'h00, 1'b1},
    {1'b0, 8'hFF, 8'h00, 1'b0}
  };

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #1;
    req = 1'b0;
    rd_val = rdata;
  endtask

  task automatic cand(input logic v, input logic [9:0] id, input logic [7:0] p, input logic [2:0] s);
    cand_valid = v; cand_id = id; cand_prio = p; cand_src = s; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 reset irq", 32'(irq), 0);
    rd(2'd0); chk("R10 reset ctrl", rd_val, 0);
    rd(2'd1); chk("R10 reset mask", rd_val, 0);

    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 32'(VEC[i][17]));
      wr(2'd1, 32'(VEC[i][16:9]));
      cand(1'b1, 10'd40, VEC[i][8:1], 3'd0);
      chk(VEC[i][17] ? "R2 mask compare" : "R1 disabled", 32'(irq), 32'(VEC[i][0]));
    end

    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0); chk("R10 ctrl readback", rd_val, 1);
    wr(2'd1, 32'h0000_12F0); rd(2'd1); chk("R10 mask readback", rd_val, 32'hF0);
    rd(2'd3); chk("R10 eoi reads zero", rd_val, 0);

    // spurious
    cand(1'b0, 10'd50, 8'hA0, 3'd0);
    rd(2'd2); chk("R4 spurious id", rd_val, 1023); chk("R4 no ack", 32'(ack), 0);
    cand(1'b1, 10'd50, 8'hA0, 3'd0);
    chk("R4 state unchanged", 32'(irq), 1);

    // id range
    cand(1'b1, 10'd1021, 8'h10, 3'd0);
    chk("R5 id 1021 blocked", 32'(irq), 0);
    rd(2'd2); chk("R5 read spurious", rd_val, 1023);
    cand(1'b1, 10'd1020, 8'h10, 3'd0);
    chk("R5 id 1020 ok", 32'(irq), 1);

    // claim id 50
    cand(1'b1, 10'd50, 8'hA0, 3'd0);
    rd(2'd2);
    chk("R3 ack value", rd_val, 50);
    chk("R3 ack pulse", 32'(ack), 1);
    chk("R3 ack id", 32'(ack_id), 50);
    chk("R3 irq drop", 32'(irq), 0);

    wr(2'd3, 32'd51);
    chk("R7 mismatch no eoi", 32'(eoi), 0);
    chk("R7 still active", 32'(irq), 0);

    // nesting
    cand(1'b1, 10'd60, 8'h80, 3'd0);
    chk("R8 preempt", 32'(irq), 1);
    cand(1'b1, 10'd61, 8'hA0, 3'd0);
    chk("R8 equal blocked", 32'(irq), 0);
    cand(1'b1, 10'd60, 8'h80, 3'd0);
    rd(2'd2); chk("R3 nested ack", rd_val, 60);
    cand(1'b1, 10'd70, 8'h10, 3'd0);
    chk("R8 full blocks", 32'(irq), 0);

    // retire 60 while still presented: level repend
    cand(1'b1, 10'd60, 8'h80, 3'd0);
    wr(2'd3, 32'd60);
    chk("R6 eoi pulse", 32'(eoi), 1);
    chk("R6 eoi id", 32'(eoi_id), 60);
    chk("R9 immediate reassert", 32'(irq), 1);
    rd(2'd2); chk("R9 reclaim", rd_val, 60);
    wr(2'd3, 32'd60);
    wr(2'd3, 32'd50);
    chk("R6 outer retire", 32'(eoi_id), 50);
    wr(2'd3, 32'd50);
    chk("R7 empty ignored", 32'(eoi), 0);

    // software-generated id with source cpu
    cand(1'b1, 10'd3, 8'h20, 3'd5);
    rd(2'd2); chk("R3 sgi value", rd_val, 32'h1403);
    cand(1'b0, 10'd0, 8'h00, 3'd0);
    wr(2'd3, 32'd3);
    chk("R7 wrong src", 32'(eoi), 0);
    wr(2'd3, 32'h0001_1403);
    chk("R7 upper bits", 32'(eoi), 0);
    wr(2'd3, 32'h1403);
    chk("R6 sgi eoi", 32'(eoi), 1);
    chk("R6 sgi eoi id", 32'(eoi_id), 3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule